// File: doc/BRIEF.md
# 32-Pin Memory-Mapped GPIO Controller

This block drives and senses 32 general-purpose pins under control of a simple word-addressed register bus. Each pin has an output value, a drive enable and an open-drain enable. Two 2-bit selectors per pin choose where the output value and the drive enable come from: the block's own registers, or one of three alternate-function sources brought in on dedicated ports. The results appear on per-pin pad output and pad output-enable signals.

The pad input levels pass through a two-stage synchroniser and can be read back as one word. The register file also holds three receive-select words and six input-select words. These are stored and read back but do not change pin behaviour.

Pins are numbered from the most significant end. Pin n sits at bit 31−n of every per-pin word, including the pad and alternate-source ports.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, every writable register reads as zero, and `pad_out` and `pad_oe` are all zero. Every pin is then floating, push-pull, with register sources selected.
- R2: A read is accepted on a clock edge where `req_valid`=1 and `req_write`=0. `rsp_valid` is 1 for exactly the following cycle, and `rsp_rdata` carries the word. A write never raises `rsp_valid`.
- R3: `req_addr` is a word index: byte offset / 4. The words are:
  - 0: output value
  - 1: drive enable
  - 2: output-source select for pins 0–15
  - 3: output-source select for pins 16–31
  - 4: enable-source select for pins 0–15
  - 5: enable-source select for pins 16–31
  - 6: open-drain enable
  - 7: input level (read-only)
  - 8–10: receive-select
  - 11: reserved
  - 12–17: input-select

  A write stores `req_wdata` into the addressed writable word, and a later read returns it.
- R4: Pin n maps to bit 31−n in the output, drive, open-drain and input words, in `pad_in`, `pad_out` and `pad_oe`, and in every alternate-source port.
- R5: When a pin's output-source and enable-source selectors are both 0 and open-drain is off, `pad_out` equals the pin's output-value bit, and `pad_oe` equals its drive bit (1 = driven, 0 = floating).
- R6: Pin p's selector field is bits [31−2·(p mod 16) : 30−2·(p mod 16)]. Pins 0–15 use the low select word and pins 16–31 use the high word.
- R7: Selector value 1, 2 or 3 takes the value (output select) or the enable (enable select) from alternate source 1, 2 or 3: `altN_out` / `altN_oe`. The two selectors are independent.
- R8: With a pin's open-drain bit set, its `pad_out` is 0, and its `pad_oe` is the selected enable AND NOT the selected value.
- R9: A `pad_in` change is visible to a read accepted on the third clock edge after the change. Reads accepted on the first and second edges return the earlier level.
- R10: The input word (7), the reserved word (11) and word indices 18–63 ignore writes. Words 11 and 18–63 read as zero.
- R11: Writing the receive-select and input-select words leaves `pad_out` and `pad_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| alt1_out | input | 32 | Alternate source 1 output values |
| alt1_oe | input | 32 | Alternate source 1 enables |
| alt2_out | input | 32 | Alternate source 2 output values |
| alt2_oe | input | 32 | Alternate source 2 enables |
| alt3_out | input | 32 | Alternate source 3 output values |
| alt3_oe | input | 32 | Alternate source 3 enables |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The checker assumes that `rst` is held for at least one clock edge before the first request, and that `pad_in` and the request signals are stable around every clock edge. The stimulus changes all inputs only on falling edges, so every edge sees settled values. The synchroniser check also needs `pad_in` to be driven with known levels from time zero. The bench drives it from its first statement. The bench then sweeps every value pair of the two selectors in both open-drain settings, and adds many pseudo-random register configurations.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
    localparam int NPIN  = 32;
    localparam int DW    = 32;
    localparam int NALT  = 3;
    localparam int NRX   = 3;
    localparam int NIS   = 6;
    localparam int NWORD = 18;
    localparam int HALF  = NPIN / 2;

    typedef enum int {
        W_OUT = 0, W_DRV = 1, W_OSL = 2, W_OSH = 3, W_TSL = 4, W_TSH = 5,
        W_ODR = 6, W_INP = 7, W_RX0 = 8, W_RSV = 11, W_IS0 = 12
    } reg_word_e;

    typedef struct packed {
        logic [DW-1:0] out;
        logic [DW-1:0] drv;
        logic [DW-1:0] osl;
        logic [DW-1:0] osh;
        logic [DW-1:0] tsl;
        logic [DW-1:0] tsh;
        logic [DW-1:0] od;
    } pin_cfg_t;

    function automatic int pin_bit(input int pin);
        return NPIN - 1 - pin;
    endfunction

    function automatic logic [1:0] sel_field(input logic [DW-1:0] lo,
                                             input logic [DW-1:0] hi,
                                             input int pin);
        int top;
        top = DW - 1 - 2 * (pin % HALF);
        return (pin < HALF) ? lo[top -: 2] : hi[top -: 2];
    endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_ctl_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [DW-1:0]    in_level,
    output pin_cfg_t         cfg_q,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] rx_q [NRX];
    logic [DW-1:0] is_q [NIS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (int'(wr_idx))
                W_OUT:   cfg_q.out <= wr_data;
                W_DRV:   cfg_q.drv <= wr_data;
                W_OSL:   cfg_q.osl <= wr_data;
                W_OSH:   cfg_q.osh <= wr_data;
                W_TSL:   cfg_q.tsl <= wr_data;
                W_TSH:   cfg_q.tsh <= wr_data;
                W_ODR:   cfg_q.od  <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NRX; i++) begin : g_rx
        always_ff @(posedge clk) begin
            if (rst)
                rx_q[i] <= '0;
            else if (wr_en && int'(wr_idx) == int'(W_RX0) + i)
                rx_q[i] <= wr_data;
        end
    end

    for (genvar i = 0; i < NIS; i++) begin : g_is
        always_ff @(posedge clk) begin
            if (rst)
                is_q[i] <= '0;
            else if (wr_en && int'(wr_idx) == int'(W_IS0) + i)
                is_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (int'(rd_idx))
            W_OUT:   rd_data = cfg_q.out;
            W_DRV:   rd_data = cfg_q.drv;
            W_OSL:   rd_data = cfg_q.osl;
            W_OSH:   rd_data = cfg_q.osh;
            W_TSL:   rd_data = cfg_q.tsl;
            W_TSH:   rd_data = cfg_q.tsh;
            W_ODR:   rd_data = cfg_q.od;
            W_INP:   rd_data = in_level;
            default: ;
        endcase
        for (int i = 0; i < NRX; i++)
            if (int'(rd_idx) == int'(W_RX0) + i) rd_data = rx_q[i];
        for (int i = 0; i < NIS; i++)
            if (int'(rd_idx) == int'(W_IS0) + i) rd_data = is_q[i];
    end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_ctl_pkg::*;
(
    input  pin_cfg_t      cfg,
    input  logic [DW-1:0] alt_val [NALT],
    input  logic [DW-1:0] alt_en  [NALT],
    output logic [DW-1:0] pad_out,
    output logic [DW-1:0] pad_oe
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        localparam int B = pin_bit(p);
        logic [1:0] osel, tsel, oi, ti;
        logic       val, en;

        always_comb begin
            osel = sel_field(cfg.osl, cfg.osh, p);
            tsel = sel_field(cfg.tsl, cfg.tsh, p);
            oi   = osel - 2'd1;
            ti   = tsel - 2'd1;
            val  = (osel == 2'b00) ? cfg.out[B] : alt_val[oi][B];
            en   = (tsel == 2'b00) ? cfg.drv[B] : alt_en[ti][B];
            if (cfg.od[B]) begin
                pad_out[B] = 1'b0;
                pad_oe[B]  = en & ~val;
            end else begin
                pad_out[B] = val;
                pad_oe[B]  = en;
            end
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_ctl_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_addr,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    input  logic [31:0]      alt1_out,
    input  logic [31:0]      alt1_oe,
    input  logic [31:0]      alt2_out,
    input  logic [31:0]      alt2_oe,
    input  logic [31:0]      alt3_out,
    input  logic [31:0]      alt3_oe,
    input  logic [31:0]      pad_in,
    output logic [31:0]      pad_out,
    output logic [31:0]      pad_oe
);
    pin_cfg_t      cfg_q;
    logic [DW-1:0] in_sync;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] alt_val [NALT];
    logic [DW-1:0] alt_en  [NALT];
    logic          rd_req;

    assign alt_val[0] = alt1_out;
    assign alt_val[1] = alt2_out;
    assign alt_val[2] = alt3_out;
    assign alt_en[0]  = alt1_oe;
    assign alt_en[1]  = alt2_oe;
    assign alt_en[2]  = alt3_oe;
    assign rd_req     = req_valid & ~req_write;

    gpio_in_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(in_sync)
    );

    gpio_regfile #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(req_valid & req_write), .wr_idx(req_addr), .wr_data(req_wdata),
        .rd_idx(req_addr), .in_level(in_sync),
        .cfg_q(cfg_q), .rd_data(rd_data)
    );

    gpio_pin_mux u_mux (
        .cfg(cfg_q), .alt_val(alt_val), .alt_en(alt_en),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= rd_req ? rd_data : '0;
        end
    end
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk
    import gpio_ctl_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [IDX_W-1:0] req_addr,
    input logic [31:0]      req_wdata,
    input logic             rsp_valid,
    input logic [31:0]      rsp_rdata,
    input logic [31:0]      pad_in,
    input logic [31:0]      pad_out,
    input logic [31:0]      out_q,
    input logic [31:0]      od_q,
    input logic [31:0]      in_sync
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)          cyc <= '0;
        else if (cyc < 3) cyc <= cyc + 2'd1;
    end

    a_r2_read_responds: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    a_r3_out_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && int'(req_addr) == int'(W_OUT))
        |=> out_q == $past(req_wdata));

    a_r8_od_never_high: assert property (@(posedge clk) disable iff (rst)
        (pad_out & od_q) == 32'h0);

    a_r9_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2) |-> in_sync == $past(pad_in, 2));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write &&
         (int'(req_addr) >= NWORD || int'(req_addr) == int'(W_RSV)))
        |=> rsp_rdata == 32'h0);
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out),
    .out_q(cfg_q.out), .od_q(cfg_q.od), .in_sync(in_sync)
);

// File: tb/tb_gpio_pin_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_pin_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] a1o = '0, a1e = '0, a2o = '0, a2e = '0, a3o = '0, a3e = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;

    int n_chk = 0, n_fail = 0;
    logic [31:0] c_out, c_drv, c_osl, c_osh, c_tsl, c_tsh, c_od;

    always #5 clk = ~clk;

    gpio_pin_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .alt1_out(a1o), .alt1_oe(a1e), .alt2_out(a2o), .alt2_oe(a2e),
        .alt3_out(a3o), .alt3_oe(a3e),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_write(input int idx, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(idx); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R2 no rsp on write", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        d = rsp_rdata;
    endtask

    function automatic logic [1:0] fld(input logic [31:0] lo, input logic [31:0] hi, input int p);
        logic [31:0] w;
        w = (p < 16) ? lo : hi;
        return 2'((w >> (30 - 2 * (p % 16))) & 32'h3);
    endfunction

    // bench model of the pad outputs from R4-R8
    task automatic expect_pads(output logic [31:0] eo, output logic [31:0] ee);
        eo = '0; ee = '0;
        for (int p = 0; p < 32; p++) begin
            int b;
            logic [1:0] s, t;
            logic v, e;
            b = 31 - p;
            s = fld(c_osl, c_osh, p);
            t = fld(c_tsl, c_tsh, p);
            case (s) 2'd0: v = c_out[b]; 2'd1: v = a1o[b]; 2'd2: v = a2o[b]; default: v = a3o[b]; endcase
            case (t) 2'd0: e = c_drv[b]; 2'd1: e = a1e[b]; 2'd2: e = a2e[b]; default: e = a3e[b]; endcase
            if (c_od[b]) begin eo[b] = 1'b0; ee[b] = e & ~v; end
            else begin eo[b] = v; ee[b] = e; end
        end
    endtask

    task automatic load_cfg();
        bus_write(0, c_out); bus_write(1, c_drv); bus_write(2, c_osl);
        bus_write(3, c_osh); bus_write(4, c_tsl); bus_write(5, c_tsh);
        bus_write(6, c_od);
    endtask

    task automatic check_pads(input string tag);
        logic [31:0] eo, ee;
        expect_pads(eo, ee);
        check({tag, " pad_out"}, pad_out, eo);
        check({tag, " pad_oe"}, pad_oe, ee);
    endtask

    function automatic logic [31:0] rep(input logic [1:0] v);
        return {16{v}};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd, saved_o, saved_e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        for (int w = 0; w < 18; w++) begin
            if (w == 7) continue;
            bus_read(w, rd);
            check("R1 reset read", rd, 32'h0);
        end

        // R3 store and read back every writable word
        for (int w = 0; w < 18; w++) begin
            if (w == 7 || w == 11) continue;
            bus_write(w, 32'h1234_0000 ^ (32'(w) * 32'h0101_0101));
        end
        for (int w = 0; w < 18; w++) begin
            if (w == 7 || w == 11) continue;
            bus_read(w, rd);
            check("R3 readback", rd, 32'h1234_0000 ^ (32'(w) * 32'h0101_0101));
        end

        // R4/R5 MSB-first: pin 0 only, then pin 31 only
        c_osl = 0; c_osh = 0; c_tsl = 0; c_tsh = 0; c_od = 0;
        c_out = 32'h8000_0000; c_drv = 32'h8000_0000; load_cfg();
        check("R4 pin0 out", pad_out, 32'h8000_0000);
        check("R4 pin0 oe", pad_oe, 32'h8000_0000);
        c_out = 32'h0000_0001; c_drv = 32'h0000_0003; load_cfg();
        check("R4 pin31 out", pad_out, 32'h0000_0001);
        check("R5 drive", pad_oe, 32'h0000_0003);

        // R6/R7/R8 sweep of all selector pairs, both open-drain settings
        a1o = 32'hF0F0_3C3C; a1e = 32'hFF00_AA55;
        a2o = 32'h0FF0_C3A5; a2e = 32'h5A5A_00FF;
        a3o = 32'h3333_CCCC; a3e = 32'hA5A5_F00F;
        c_out = 32'h6969_1E1E; c_drv = 32'h9696_E1E1;
        for (int odm = 0; odm < 2; odm++)
            for (int s = 0; s < 4; s++)
                for (int t = 0; t < 4; t++) begin
                    c_od = odm ? 32'hFFFF_FFFF : 32'h0;
                    c_osl = rep(2'(s)); c_osh = rep(2'(s));
                    c_tsl = rep(2'(t)); c_tsh = rep(2'(t));
                    load_cfg();
                    check_pads(odm ? "R8 sweep" : "R7 sweep");
                end

        // R6 per-pin fields, mixed open-drain: pseudo-random configurations
        for (int k = 0; k < 120; k++) begin
            c_out = $urandom; c_drv = $urandom; c_osl = $urandom; c_osh = $urandom;
            c_tsl = $urandom; c_tsh = $urandom; c_od = $urandom;
            a1o = $urandom; a1e = $urandom; a2o = $urandom; a2e = $urandom;
            a3o = $urandom; a3e = $urandom;
            load_cfg();
            check_pads("R6 random");
        end

        // R11 select storage has no effect on pads
        saved_o = pad_out; saved_e = pad_oe;
        for (int w = 8; w < 18; w++) begin
            if (w == 11) continue;
            bus_write(w, 32'hFFFF_FFFF ^ 32'(w));
        end
        check("R11 pad_out", pad_out, saved_o);
        check("R11 pad_oe", pad_oe, saved_e);

        // R10 ignored writes
        bus_write(11, 32'hFFFF_FFFF); bus_write(18, 32'hFFFF_FFFF);
        bus_write(63, 32'hFFFF_FFFF); bus_write(7, 32'hFFFF_FFFF);
        bus_write(40, 32'h5555_5555); bus_write(50, 32'hAAAA_AAAA);
        check("R10 pad_out", pad_out, saved_o);
        check("R10 pad_oe", pad_oe, saved_e);
        bus_read(11, rd); check("R10 reserved", rd, 32'h0);
        bus_read(18, rd); check("R10 unmapped 18", rd, 32'h0);
        bus_read(63, rd); check("R10 unmapped 63", rd, 32'h0);
        bus_read(2, rd);  check("R10 no alias", rd, c_osl);
        bus_read(6, rd);  check("R10 no alias od", rd, c_od);
        bus_read(7, rd);  check("R10 input unaffected", rd, 32'h0);

        // R9 synchroniser latency, several patterns
        begin
            logic [31:0] prev;
            prev = 32'h0;
            for (int k = 0; k < 6; k++) begin
                logic [31:0] v;
                v = (k == 0) ? 32'h8000_0001 : $urandom;
                pad_in = v;
                bus_read(7, rd); check("R9 edge1 old", rd, prev);
                bus_read(7, rd); check("R9 edge2 old", rd, prev);
                bus_read(7, rd); check("R9 edge3 new", rd, v);
                prev = v;
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule